// File: doc/BRIEF.md
# Scratch Register with FIFO-Level Readback Swap

This block is one slice of a UART register file. It holds an 8-bit general-purpose scratch byte and a small write-only mode register that share one bus address. It also holds the read multiplexer that decides what a read of that address returns. A swap-enable control input chooses the meaning of the address. With swap off, the address is an ordinary read/write scratch byte. With swap on, writes program a 2-bit mode field. Reads then return the receive FIFO fill level, the transmit fill level, or the two levels in turn on successive reads.

Software uses the swap window to poll both FIFO levels through one address. It does this without disturbing the stored scratch byte, which keeps its value across any amount of swap activity. The byte also holds while the device idles or sleeps, since nothing other than a bus write with swap off changes it. In alternating mode, rewriting the mode field puts the sequence back to its first element, the receive count.

Top module: `swp_scratch_swap`

## Requirements
- R1: After reset, the scratch byte is 0xFF, the mode field is 00, the alternation phase is "receive", and `bus_rdata` is 0x00.
- R2: With `swap_en` = 0, a write strobe at the scratch address stores `bus_wdata`. A read strobe at that address returns the stored byte on `bus_rdata` in the cycle after the strobe.
- R3: With `swap_en` = 0, the mode field has no effect: reads return the scratch byte whatever mode was last written.
- R4: With `swap_en` = 1, a write at the scratch address goes to the mode field only. The scratch byte is left unchanged, as seen by a later read with `swap_en` = 0.
- R5: With `swap_en` = 1 and mode 00 or 10, a read returns `rx_level`, sampled in the strobe cycle and zero-extended to 8 bits.
- R6: With `swap_en` = 1 and mode 01, a read returns `tx_level`, sampled in the strobe cycle.
- R7: With `swap_en` = 1 and mode 11, successive reads return receive, transmit, receive, transmit and so on. The phase advances only on a read strobe at the scratch address.
- R8: Any write to the mode field (`swap_en` = 1, scratch address) returns the alternation phase to receive, so the next mode-11 read returns the receive count.
- R9: Only bits 1:0 of the written byte set the mode. Bits 7:2 are ignored, so 0xFD acts as mode 01 and 0x0F acts as mode 11.
- R10: Strobes at any other address change neither the scratch byte, the mode, the phase, nor `bus_rdata`.
- R11: `bus_rdata` holds its value in every cycle without a read strobe at the scratch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register address; the scratch address is parameter SCRATCH_ADDR (default 7) |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read strobe |
| swap_en | input | 1 | 1 = scratch address is the FIFO-level window |
| rx_level | input | 8 | Receive FIFO fill level |
| tx_level | input | 8 | Transmit FIFO fill level |

## Verification
Each read result appears on `bus_rdata` one clock after its strobe. The levels and the scratch byte are taken as they stand at that strobe edge. A write takes effect at its own edge, so a read issued on the next cycle already sees the new byte, mode or cleared phase. The bench drives inputs on the falling edge and logs every scratch read on the following rising edge. It compares one half-cycle later against the value queued by the driver, which the driver computed from the levels it presented. Hold checks for R10 and R11 sample the output on falling edges across several idle or foreign-address cycles.

// File: rtl/swp_pkg.sv
// Package: shared types for the scratch/FIFO-level swap slice.
// Assumes level inputs are no wider than the 8-bit data bus.
package swp_pkg;

    localparam int DATA_W = 8;

    // Mode field values; 00 and 10 both select the receive level.
    typedef enum logic [1:0] {
        MODE_RX_A = 2'b00,
        MODE_TX   = 2'b01,
        MODE_RX_B = 2'b10,
        MODE_ALT  = 2'b11
    } swp_mode_t;

    // Source picked by the read multiplexer.
    typedef enum logic [1:0] {
        SRC_SCRATCH = 2'd0,
        SRC_RX      = 2'd1,
        SRC_TX      = 2'd2
    } swp_src_t;

    // Alternation phase of mode 11.
    typedef enum logic {
        PH_RX = 1'b0,
        PH_TX = 1'b1
    } swp_phase_t;

endpackage

// File: rtl/swp_scratch_reg.sv
// Scratch byte storage.
// Loads only when the decoder flags a plain (swap-off) write; otherwise it
// holds indefinitely, which covers retention during idle or sleep.
module swp_scratch_reg #(
    parameter int          DATA_W    = 8,
    parameter logic [7:0]  RESET_VAL = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);

    // Purpose: hold the byte; reset to the documented default.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RESET_VAL[DATA_W-1:0];
        else if (load)
            q <= din;
    end

endmodule

// File: rtl/swp_mode_ctl.sv
// Mode field and alternation phase.
// Assumes one strobe per access. A mode write and a read strobe in the same
// cycle resolve in favour of the write (phase goes back to receive).
module swp_mode_ctl
    import swp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [DATA_W-1:0] din,
    input  logic              win_rd,
    output swp_mode_t         mode,
    output swp_phase_t        phase
);

    logic step;

    // Purpose: advance the phase only on window reads in alternating mode.
    always_comb begin
        step = win_rd && (mode == MODE_ALT);
    end

    // Purpose: capture bits 1:0 of a mode write; upper bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= MODE_RX_A;
        else if (mode_wr)
            mode <= swp_mode_t'(din[1:0]);
    end

    // Purpose: track receive/transmit turn; any mode write restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_RX;
        else if (mode_wr)
            phase <= PH_RX;
        else if (step)
            phase <= (phase == PH_RX) ? PH_TX : PH_RX;
    end

endmodule

// File: rtl/swp_read_mux.sv
// Read source selection and registered read data.
// The levels are sampled in the strobe cycle. Narrow levels are zero-extended.
module swp_read_mux
    import swp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hit,
    input  logic              swap_en,
    input  swp_mode_t         mode,
    input  swp_phase_t        phase,
    input  logic [DATA_W-1:0] scratch,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    output logic [DATA_W-1:0] rdata
);

    localparam int PAD_W = DATA_W - LVL_W;

    swp_src_t          src;
    logic [DATA_W-1:0] rx_ext;
    logic [DATA_W-1:0] tx_ext;
    logic [DATA_W-1:0] sel;

    // Purpose: widen the level inputs to the bus width.
    generate
        if (PAD_W > 0) begin : g_pad
            assign rx_ext = {{PAD_W{1'b0}}, rx_level};
            assign tx_ext = {{PAD_W{1'b0}}, tx_level};
        end else begin : g_nopad
            assign rx_ext = rx_level[DATA_W-1:0];
            assign tx_ext = tx_level[DATA_W-1:0];
        end
    endgenerate

    // Purpose: decode swap, mode and phase into a source.
    always_comb begin
        if (!swap_en) begin
            src = SRC_SCRATCH;
        end else begin
            unique case (mode)
                MODE_RX_A, MODE_RX_B: src = SRC_RX;
                MODE_TX:              src = SRC_TX;
                MODE_ALT:             src = (phase == PH_RX) ? SRC_RX : SRC_TX;
                default:              src = SRC_RX;
            endcase
        end
    end

    // Purpose: steer the chosen source onto the data path.
    always_comb begin
        unique case (src)
            SRC_RX:  sel = rx_ext;
            SRC_TX:  sel = tx_ext;
            default: sel = scratch;
        endcase
    end

    // Purpose: register read data on a window read; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_hit)
            rdata <= sel;
    end

endmodule

// File: rtl/swp_scratch_swap.sv
// Top: scratch byte that doubles as a FIFO-level window.
// Decodes the bus strobes at SCRATCH_ADDR. Plain writes go to the scratch
// register when swap is off; they go to the mode field when swap is on.
module swp_scratch_swap
    import swp_pkg::*;
#(
    parameter int               ADDR_W       = 3,
    parameter int               LVL_W        = 8,
    parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 3'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              swap_en,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level
);

    logic       hit;
    logic       scr_load;
    logic       mode_wr;
    logic       rd_hit;
    logic [7:0] scratch_q;
    swp_mode_t  mode_q;
    swp_phase_t phase_q;

    // Purpose: address decode and routing of the write strobe.
    always_comb begin
        hit      = (bus_addr == SCRATCH_ADDR);
        scr_load = hit && bus_wr && !swap_en;
        mode_wr  = hit && bus_wr && swap_en;
        rd_hit   = hit && bus_rd;
    end

    swp_scratch_reg #(.DATA_W(DATA_W), .RESET_VAL(8'hFF)) u_scratch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (scr_load),
        .din   (bus_wdata),
        .q     (scratch_q)
    );

    swp_mode_ctl #(.DATA_W(DATA_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_wr),
        .din     (bus_wdata),
        .win_rd  (rd_hit && swap_en),
        .mode    (mode_q),
        .phase   (phase_q)
    );

    swp_read_mux #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hit   (rd_hit),
        .swap_en  (swap_en),
        .mode     (mode_q),
        .phase    (phase_q),
        .scratch  (scratch_q),
        .rx_level (rx_level),
        .tx_level (tx_level),
        .rdata    (bus_rdata)
    );

endmodule

// File: rtl/swp_scratch_swap_chk.sv
// Checker for swp_scratch_swap, bound to every instance of the top.
// Observes the bus ports and the scratch, mode and phase state.
module swp_scratch_swap_chk
    import swp_pkg::*;
#(
    parameter int               ADDR_W       = 3,
    parameter int               LVL_W        = 8,
    parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 3'd7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic              swap_en,
    input logic [LVL_W-1:0]  rx_level,
    input logic [LVL_W-1:0]  tx_level,
    input logic [7:0]        scratch_q,
    input swp_mode_t         mode_q,
    input swp_phase_t        phase_q
);

    logic at_win;
    assign at_win = (bus_addr == SCRATCH_ADDR);

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && at_win) |=> $stable(bus_rdata)); // R11

    AST_PLAIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_win && !swap_en) |=> (bus_rdata == $past(scratch_q))); // R2

    AST_SCRATCH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_win && swap_en) |=> $stable(scratch_q)); // R4

    AST_RX_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_win && swap_en && !mode_q[0])
        |=> (bus_rdata == 8'($past(rx_level)))); // R5

    AST_TX_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_win && swap_en && mode_q == MODE_TX)
        |=> (bus_rdata == 8'($past(tx_level)))); // R6

    AST_ALT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_win && swap_en && mode_q == MODE_ALT && !bus_wr)
        |=> (phase_q != $past(phase_q))); // R7

    AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_win && swap_en) |=> (phase_q == PH_RX)); // R8

    AST_FOREIGN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !at_win |=> ($stable(scratch_q) && $stable(mode_q) && $stable(phase_q))); // R10

endmodule

bind swp_scratch_swap swp_scratch_swap_chk #(
    .ADDR_W(ADDR_W), .LVL_W(LVL_W), .SCRATCH_ADDR(SCRATCH_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .swap_en   (swap_en),
    .rx_level  (rx_level),
    .tx_level  (tx_level),
    .scratch_q (scratch_q),
    .mode_q    (mode_q),
    .phase_q   (phase_q)
);

// File: tb/swp_scratch_swap_tb.sv
// Scoreboard bench: the driver queues the expected read data and the
// monitor compares each scratch-address read one cycle after its strobe.
module swp_scratch_swap_tb_top;

    localparam logic [2:0] WIN = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       swap_en = 1'b0;
    logic [7:0] rx_level = '0;
    logic [7:0] tx_level = '0;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    swp_scratch_swap dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .swap_en(swap_en), .rx_level(rx_level), .tx_level(tx_level)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Log a window read at the edge that captures it.
    always @(posedge clk) rd_seen = bus_rd && (bus_addr == WIN) && rst_n;

    // Monitor: compare the registered result half a cycle after capture.
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL SB unexpected read actual=%02h expected=none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] exp,
                      input logic [7:0] rxl, input logic [7:0] txl);
        rx_level = rxl; tx_level = txl;
        bus_addr = WIN; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(req);
        @(negedge clk);
        bus_rd = 1'b0;
        rx_level = ~rxl; tx_level = ~txl;
    endtask

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after reset", bus_rdata, 8'h00);
        rd("R1 scratch reset 0xFF", 8'hFF, 8'h11, 8'h22);
        swap_en = 1'b1;
        rd("R1 mode reset 00 gives rx", 8'h33, 8'h33, 8'h44);
        swap_en = 1'b0;

        wr(WIN, 8'hA5);
        rd("R2 scratch read back", 8'hA5, 8'h01, 8'h02);
        wr(WIN, 8'h3C);
        rd("R2 scratch second value", 8'h3C, 8'h01, 8'h02);

        swap_en = 1'b1; wr(WIN, 8'h01); swap_en = 1'b0;
        rd("R3 mode ignored with swap off", 8'h3C, 8'h55, 8'h66);

        swap_en = 1'b1; wr(WIN, 8'h5A); swap_en = 1'b0;
        rd("R4 scratch kept after swap write", 8'h3C, 8'h00, 8'h00);

        swap_en = 1'b1;
        wr(WIN, 8'h00);
        rd("R5 mode 00 rx", 8'h7F, 8'h7F, 8'h10);
        wr(WIN, 8'h02);
        rd("R5 mode 10 rx", 8'h80, 8'h80, 8'h10);
        rd("R5 mode 10 rx again", 8'h05, 8'h05, 8'h10);
        wr(WIN, 8'h01);
        rd("R6 mode 01 tx", 8'h40, 8'h12, 8'h40);
        rd("R6 mode 01 tx repeat", 8'h00, 8'h12, 8'h00);

        wr(WIN, 8'h03);
        rd("R7 alt 1st rx", 8'h21, 8'h21, 8'h31);
        rd("R7 alt 2nd tx", 8'h32, 8'h22, 8'h32);
        rd("R7 alt 3rd rx", 8'h23, 8'h23, 8'h33);
        rd("R7 alt 4th tx", 8'h34, 8'h24, 8'h34);
        rd("R7 alt 5th rx", 8'h25, 8'h25, 8'h35);
        wr(WIN, 8'h03);
        rd("R8 restart rx", 8'h41, 8'h41, 8'h51);
        rd("R8 then tx", 8'h52, 8'h42, 8'h52);
        wr(WIN, 8'h03);
        rd("R8 restart after tx", 8'h43, 8'h43, 8'h53);

        wr(WIN, 8'hFD);
        rd("R9 0xFD acts as tx", 8'h66, 8'h77, 8'h66);
        wr(WIN, 8'h0F);
        rd("R9 0x0F alt rx", 8'h19, 8'h19, 8'h29);
        rd("R9 0x0F alt tx", 8'h2A, 8'h1A, 8'h2A);

        // R10: foreign-address strobes, mode stays 11 with phase at rx.
        wr(WIN, 8'h03);
        rd("R10 setup rx", 8'h61, 8'h61, 8'h71);
        held = bus_rdata;
        bus_addr = 3'd2; bus_rd = 1'b1; @(negedge clk); bus_rd = 1'b0;
        check("R10 rdata unchanged on foreign read", bus_rdata, held);
        wr(3'd3, 8'h00);
        check("R10 rdata unchanged on foreign write", bus_rdata, held);
        rd("R10 phase not advanced by foreign read", 8'h72, 8'h62, 8'h72);
        swap_en = 1'b0;
        wr(3'd0, 8'h99);
        rd("R10 scratch untouched by foreign write", 8'h3C, 8'h00, 8'h00);

        // R11: hold with no strobe while levels move.
        @(negedge clk);
        held = bus_rdata;
        for (int i = 0; i < 5; i++) begin
            rx_level = 8'(i * 17); tx_level = 8'(i * 29);
            swap_en = i[0];
            @(negedge clk);
            check("R11 rdata holds without strobe", bus_rdata, held);
        end
        swap_en = 1'b0;
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL SB missing reads actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL WATCHDOG actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule